// File: doc/BRIEF.md
# Platform Interrupt Target Arbiter

This block is the per-target slice of a platform interrupt controller. It serves one hart context. It stores an enable bit for each of 52 global interrupt sources and a 3-bit priority threshold. Each clock it picks the best source that may interrupt the hart. Gateways outside the block supply a pending flag and a 3-bit priority for every source. A source qualifies when all of the following hold:

- it is pending,
- it is enabled,
- it is not already being serviced,
- its priority is strictly above the threshold.

The block raises an interrupt request whenever any source qualifies. The hart handles the interrupt in two steps. First it reads the claim register, which returns the winning source ID and marks that source in service. When the handler is finished, it writes the same ID back to the claim register to signal completion. Source IDs start at 1. A claim value of 0 means no source qualified.

All registers sit behind a simple 32-bit port with separate read and write strobes and a full-width byte address:

- The enable bits occupy two words at `0x0C00_2000` and `0x0C00_2004`.
- The threshold is at `0x0C20_0000`.
- The claim/complete register is at `0x0C20_0004`.

Read data is registered and holds its value until the next read. The request output comes from a two-state machine:

- `ARB_IDLE` moves to `ARB_ASSERT` when a source qualifies.
- `ARB_ASSERT` moves back to `ARB_IDLE` when no source qualifies.

Top module: `intc_target_arbiter`

## Requirements
- R1: Source s (1..52) is enabled by bit (s mod 32) of the enable word at 0x0C00_2000 + 4*(s div 32). Each such bit is written by a write to that word and read back from it.
- R2: Bit 0 of the enable word at 0x0C00_2000 always reads 0 and ignores writes. Bits 31:21 of the word at 0x0C00_2004 always read 0.
- R3: The threshold register at 0x0C20_0000 stores write data bits 2:0, and every value 0..7 is legal. Reads return the threshold in bits 2:0 with zeros in bits 31:3.
- R4: A source qualifies only when it is pending, enabled, not in service, and its priority is strictly greater than the threshold. A priority of 0 never qualifies, and a threshold of 7 blocks every source.
- R5: A read of 0x0C20_0004 returns, in bits 5:0 with zeros above, the ID of the qualifying source with the largest priority, or 0 if none qualifies. `bus_rdata` shows the value after the clock edge that samples the read.
- R6: Among qualifying sources of equal priority, the lowest ID wins.
- R7: A claim that returns a nonzero ID puts that source in service. It cannot be returned by a later claim until it is completed, even while its pending input stays high.
- R8: Writing an ID to 0x0C20_0004 completes that source if it is in service. A completion for a source not in service (including ID 0) changes nothing.
- R9: `irq_o` is high exactly when the qualification result at the previous clock edge was nonempty. It changes one edge after the inputs that caused the change.
- R10: Reset clears all enables, the threshold, all in-service marks, `irq_o` and `bus_rdata`.
- R11: Reads of any other address return 0. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 52 | Pending flag per source, bit s for source s (bits 52:1) |
| prio_i | input | 156 | Priority per source, source s in bits 3*(s-1)+2 : 3*(s-1) |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the hart |

## Verification
Every result here appears exactly one rising edge after the stimulus that causes it:

- a written enable bit or threshold takes effect after the edge that samples the write,
- read data appears on `bus_rdata` after the edge that samples the read,
- `irq_o` follows a change in pending, priority, enable, threshold or in-service state one edge later.

The bench changes inputs on falling edges and samples outputs on the next falling edge. Each check therefore lands half a cycle after the edge that should produce the new value. For R9, the bench also samples `irq_o` right after an input change, before any edge, to confirm that the request has not moved early.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE   = 1'b0,
        ARB_ASSERT = 1'b1
    } arb_state_t;

    localparam int BUS_W = 32;

endpackage

// File: rtl/intc_cfg_regs.sv
`timescale 1ns/1ps
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int          NSRC        = 52,
    parameter int          PRIO_W      = 3,
    parameter logic [31:0] ENABLE_BASE = 32'h0C00_2000,
    parameter logic [31:0] THRESH_BASE = 32'h0C20_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [BUS_W-1:0]    addr,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NSRC:1]       en_o,
    output logic [PRIO_W-1:0]   thresh_o,
    output logic [BUS_W-1:0]    cfg_rdata
);

    localparam int NWORDS = (NSRC + BUS_W) / BUS_W;

    logic [NSRC:1]                   en_q;
    logic [PRIO_W-1:0]               thresh_q;
    logic [NWORDS-1:0][BUS_W-1:0]    word_view;
    logic                            thresh_hit;

    assign thresh_hit = (addr == THRESH_BASE);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        for (genvar b = 0; b < BUS_W; b++) begin : g_bit
            localparam int S = w * BUS_W + b;
            if (S >= 1 && S <= NSRC) begin : g_live
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        en_q[S] <= 1'b0;
                    else if (wr_en && addr == ENABLE_BASE + 32'(w * 4))
                        en_q[S] <= wdata[b];
                end
                assign word_view[w][b] = en_q[S];
            end else begin : g_dead
                assign word_view[w][b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            thresh_q <= '0;
        else if (wr_en && thresh_hit)
            thresh_q <= wdata[PRIO_W-1:0];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (addr == ENABLE_BASE + 32'(w * 4))
                cfg_rdata = word_view[w];
        end
        if (thresh_hit)
            cfg_rdata = {{(BUS_W-PRIO_W){1'b0}}, thresh_q};
    end

    assign en_o     = en_q;
    assign thresh_o = thresh_q;

    AST_THRESH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && thresh_hit) |=> thresh_q == $past(wdata[PRIO_W-1:0])); // R3
    AST_THRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && thresh_hit) |=> $stable(thresh_q)); // R11

endmodule

// File: rtl/intc_pick.sv
`timescale 1ns/1ps
module intc_pick #(
    parameter int NSRC   = 52,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic [NSRC:1]          pend_i,
    input  logic [NSRC:1]          en_i,
    input  logic [NSRC:1]          insvc_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thresh_i,
    output logic [ID_W-1:0]        win_id,
    output logic                   win_valid
);

    logic [NSRC:1]     elig;
    logic [PRIO_W-1:0] best_prio;
    logic [PRIO_W-1:0] cur_prio;

    assign elig = pend_i & en_i & ~insvc_i;

    // Scan from the highest ID downward; ">=" lets a lower ID take a tie.
    always_comb begin
        win_id    = '0;
        win_valid = 1'b0;
        best_prio = '0;
        cur_prio  = '0;
        for (int s = NSRC; s >= 1; s--) begin
            cur_prio = prio_i[(s-1)*PRIO_W +: PRIO_W];
            if (elig[s] && cur_prio > thresh_i &&
                (!win_valid || cur_prio >= best_prio)) begin
                win_valid = 1'b1;
                best_prio = cur_prio;
                win_id    = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/intc_service.sv
`timescale 1ns/1ps
module intc_service
    import intc_pkg::*;
#(
    parameter int NSRC = 52,
    parameter int ID_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_rd,
    input  logic             done_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [ID_W-1:0]  win_id,
    input  logic             win_valid,
    output logic [NSRC:1]    insvc_o,
    output logic             irq_o
);

    arb_state_t     state_q;
    arb_state_t     state_d;
    logic [NSRC:1]  insvc_q;
    logic [NSRC:1]  win_dec;
    logic [NSRC:1]  done_dec;

    for (genvar s = 1; s <= NSRC; s++) begin : g_src
        assign win_dec[s]  = (win_id == ID_W'(s));
        assign done_dec[s] = (wdata == 32'(s));

        always_ff @(posedge clk) begin
            if (!rst_n)
                insvc_q[s] <= 1'b0;
            else if (claim_rd && win_valid && win_dec[s])
                insvc_q[s] <= 1'b1;
            else if (done_wr && done_dec[s])
                insvc_q[s] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARB_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:   if (win_valid)  state_d = ARB_ASSERT;
            ARB_ASSERT: if (!win_valid) state_d = ARB_IDLE;
            default:    state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ARB_ASSERT);
    end

    assign insvc_o = insvc_q;

    AST_WINNER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_dec & insvc_q) == '0); // R7
    AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && win_valid && !done_wr) |=>
            $countones(insvc_q) == $past($countones(insvc_q)) + 1); // R7
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_wr && !claim_rd && (done_dec & insvc_q) == '0) |=> $stable(insvc_q)); // R8

endmodule

// File: rtl/intc_target_arbiter.sv
`timescale 1ns/1ps
module intc_target_arbiter
    import intc_pkg::*;
#(
    parameter int          NSRC        = 52,
    parameter int          PRIO_W      = 3,
    parameter logic [31:0] ENABLE_BASE = 32'h0C00_2000,
    parameter logic [31:0] THRESH_BASE = 32'h0C20_0000,
    parameter logic [31:0] CLAIM_BASE  = 32'h0C20_0004
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC:1]          pend_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [31:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   irq_o
);

    localparam int ID_W    = $clog2(NSRC + 1);
    localparam int NWORDS  = (NSRC + BUS_W) / BUS_W;
    localparam int LAST_W  = NWORDS - 1;
    localparam int USED_HI = NSRC + 1 - BUS_W * LAST_W;

    logic [NSRC:1]      en;
    logic [NSRC:1]      insvc;
    logic [PRIO_W-1:0]  thresh;
    logic [BUS_W-1:0]   cfg_rdata;
    logic [ID_W-1:0]    win_id;
    logic               win_valid;
    logic               claim_hit;
    logic [BUS_W-1:0]   rdata_q;

    assign claim_hit = (bus_addr == CLAIM_BASE);

    intc_cfg_regs #(
        .NSRC        (NSRC),
        .PRIO_W      (PRIO_W),
        .ENABLE_BASE (ENABLE_BASE),
        .THRESH_BASE (THRESH_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .en_o      (en),
        .thresh_o  (thresh),
        .cfg_rdata (cfg_rdata)
    );

    intc_pick #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_pick (
        .pend_i    (pend_i),
        .en_i      (en),
        .insvc_i   (insvc),
        .prio_i    (prio_i),
        .thresh_i  (thresh),
        .win_id    (win_id),
        .win_valid (win_valid)
    );

    intc_service #(
        .NSRC (NSRC),
        .ID_W (ID_W)
    ) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_rd  (bus_rd && claim_hit),
        .done_wr   (bus_wr && claim_hit),
        .wdata     (bus_wdata),
        .win_id    (win_id),
        .win_valid (win_valid),
        .insvc_o   (insvc),
        .irq_o     (irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= claim_hit ? {{(BUS_W-ID_W){1'b0}}, win_id} : cfg_rdata;
    end

    assign bus_rdata = rdata_q;

    AST_MAX_THRESH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == {PRIO_W{1'b1}}) |-> !win_valid); // R4
    AST_EMPTY_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && claim_hit && !win_valid) |=> bus_rdata == '0); // R5
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ENABLE_BASE + 32'(LAST_W * 4)) |=>
            (bus_rdata >> USED_HI) == '0); // R2
    AST_SOURCE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ENABLE_BASE) |=> !bus_rdata[0]); // R2

endmodule

// File: tb/intc_target_arbiter_test.sv
`timescale 1ns/1ps
module intc_target_arbiter_test;

    localparam logic [31:0] EN0 = 32'h0C00_2000;
    localparam logic [31:0] EN1 = 32'h0C00_2004;
    localparam logic [31:0] THR = 32'h0C20_0000;
    localparam logic [31:0] CLM = 32'h0C20_0004;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [52:1]  pend;
    logic [2:0]   prio [1:52];
    logic [155:0] prio_flat;
    logic         bus_wr, bus_rd;
    logic [31:0]  bus_addr, bus_wdata, bus_rdata;
    logic         irq;
    int           n_checks = 0;
    int           n_fail   = 0;
    logic [31:0]  rv;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int s = 1; s <= 52; s++) prio_flat[(s-1)*3 +: 3] = prio[s];
    end

    intc_target_arbiter uut (
        .clk (clk), .rst_n (rst_n), .pend_i (pend), .prio_i (prio_flat),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_o (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic clear_inputs();
        @(negedge clk);
        pend = '0;
        for (int s = 1; s <= 52; s++) prio[s] = 3'd0;
        wr(EN0, 32'h0); wr(EN1, 32'h0); wr(THR, 32'h0);
    endtask

    task automatic t_reset();
        check("R10 irq after reset", {31'b0, irq}, 32'h0);
        check("R10 rdata after reset", bus_rdata, 32'h0);
        rd(EN0, rv); check("R10 enable word 0", rv, 32'h0);
        rd(EN1, rv); check("R10 enable word 1", rv, 32'h0);
        rd(THR, rv); check("R10 threshold", rv, 32'h0);
        rd(CLM, rv); check("R10 empty claim", rv, 32'h0);
    endtask

    task automatic t_enables();
        wr(EN0, 32'hFFFF_FFFF); rd(EN0, rv); check("R2 word0 bit0 zero", rv, 32'hFFFF_FFFE);
        wr(EN1, 32'hFFFF_FFFF); rd(EN1, rv); check("R2 word1 reserved zero", rv, 32'h001F_FFFF);
        wr(EN0, 32'hA5A5_0003); rd(EN0, rv); check("R1 word0 pattern", rv, 32'hA5A5_0002);
        wr(EN1, 32'h0012_3456); rd(EN1, rv); check("R1 word1 pattern", rv, 32'h0012_3456);
    endtask

    task automatic t_unmapped();
        wr(32'h0C00_2008, 32'hFFFF_FFFF);
        wr(32'h0C20_0008, 32'hFFFF_FFFF);
        rd(32'h0C00_2008, rv); check("R11 unmapped read", rv, 32'h0);
        rd(EN0, rv); check("R11 word0 untouched", rv, 32'hA5A5_0002);
        rd(EN1, rv); check("R11 word1 untouched", rv, 32'h0012_3456);
        rd(THR, rv); check("R11 threshold untouched", rv, 32'h0);
    endtask

    task automatic t_threshold();
        wr(THR, 32'hFFFF_FFFF); rd(THR, rv); check("R3 threshold max", rv, 32'h7);
        wr(THR, 32'h0000_00F2); rd(THR, rv); check("R3 threshold two", rv, 32'h2);
        clear_inputs();
    endtask

    task automatic t_mask_and_irq();
        wr(EN0, 32'hFFFF_FFFE); wr(EN1, 32'h001F_FFFF); wr(THR, 32'd3);
        @(negedge clk); pend[5] = 1'b1; prio[5] = 3'd3;
        @(negedge clk); @(negedge clk);
        check("R4 equal to threshold no irq", {31'b0, irq}, 32'h0);
        rd(CLM, rv); check("R4 equal to threshold no claim", rv, 32'h0);
        @(negedge clk); prio[5] = 3'd4;
        #1 check("R9 irq not early", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq one edge later", {31'b0, irq}, 32'h1);
        wr(THR, 32'd7); prio[5] = 3'd7;
        @(negedge clk);
        check("R4 threshold 7 blocks", {31'b0, irq}, 32'h0);
        rd(CLM, rv); check("R4 threshold 7 no claim", rv, 32'h0);
        wr(THR, 32'd0); prio[5] = 3'd0;
        @(negedge clk); @(negedge clk);
        check("R4 priority 0 never", {31'b0, irq}, 32'h0);
        clear_inputs();
    endtask

    task automatic t_priority();
        wr(EN0, 32'hFFFF_FFFE); wr(EN1, 32'h001F_FFFF);
        @(negedge clk);
        pend[3] = 1'b1;  prio[3] = 3'd2;
        pend[40] = 1'b1; prio[40] = 3'd6;
        pend[52] = 1'b1; prio[52] = 3'd5;
        rd(CLM, rv); check("R5 highest priority", rv, 32'd40);
        wr(CLM, 32'd40);
        wr(EN1, 32'h001F_FEFF);
        rd(CLM, rv); check("R5 disabled source skipped", rv, 32'd52);
        wr(CLM, 32'd52);
        clear_inputs();
    endtask

    task automatic t_tie();
        wr(EN0, 32'hFFFF_FFFE); wr(EN1, 32'h001F_FFFF);
        @(negedge clk);
        pend[33] = 1'b1; prio[33] = 3'd4;
        pend[10] = 1'b1; prio[10] = 3'd4;
        rd(CLM, rv); check("R6 tie lower id", rv, 32'd10);
        rd(CLM, rv); check("R6 next in tie", rv, 32'd33);
        wr(CLM, 32'd10); wr(CLM, 32'd33);
        clear_inputs();
    endtask

    task automatic t_service();
        wr(EN0, 32'hFFFF_FFFE);
        @(negedge clk); pend[7] = 1'b1; prio[7] = 3'd3;
        @(negedge clk);
        rd(CLM, rv); check("R7 first claim", rv, 32'd7);
        @(negedge clk);
        check("R7 irq drops while in service", {31'b0, irq}, 32'h0);
        rd(CLM, rv); check("R7 no reclaim", rv, 32'h0);
        wr(CLM, 32'd9); wr(CLM, 32'd0);
        @(negedge clk);
        check("R8 stray completion ignored irq", {31'b0, irq}, 32'h0);
        rd(CLM, rv); check("R8 stray completion ignored claim", rv, 32'h0);
        wr(CLM, 32'd7);
        rd(CLM, rv); check("R8 completion releases", rv, 32'd7);
        wr(CLM, 32'd7);
        clear_inputs();
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; pend = '0;
        for (int s = 1; s <= 52; s++) prio[s] = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_unmapped();
        t_threshold();
        t_mask_and_irq();
        t_priority();
        t_tie();
        t_service();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule